// File: doc/BRIEF.md
# Ethernet PHY Basic Mode Control Register

This block holds the basic mode control word of an Ethernet PHY management register file. The serial management framing is decoded elsewhere and delivered as a single-cycle write strobe with an address and a 16-bit data word. The read data is combinational on the address. The reset values of the word come from strap pins, so a board can boot with auto-negotiation or isolation already selected. The block also drives the soft-reset and recalibration handshake with the analog side. A calibration request pulse leaves the block, and a calibration-done input ends the busy phase.

The block resolves link speed and duplex. These come from the register bits while auto-negotiation is off, and from the negotiation result while it is on. Any change in the resolved mode starts a new recalibration. A loopback pin can force the loopback control on and off through its edges. The media-independent interface signals pass through the block. It gates them for isolation and turns them round for loopback.

Top module: `phy_basic_ctrl`

## Requirements
- R1: At reset, auto-negotiation enable and speed select both load 1 when `strap_an` is nonzero and 0 otherwise. Isolate loads 1 when `strap_phy_addr` is all zeros, and otherwise loads `strap_iso_dflt`. Every other bit loads 0.
- R2: A read at address 0 returns {bit15 busy, 14 loopback, 13 speed, 12 autoneg enable, 11 power down, 10 isolate, 9 zero, 8 full duplex, 7 collision test, 6..0 zero}. Bits 14..10, 8 and 7 take written values, and these bits also drive their control outputs. Reserved bits ignore writes. Any other address reads all zeros.
- R3: A write with bit 15 set reloads the R1 defaults and ignores the other data bits. It pulses `cal_start` in the following cycle. Bit 15 then reads 1 until the clock edge that samples `cal_done` high, and reads 0 from the cycle after that edge.
- R4: Register writes that arrive while bit 15 reads 1 are ignored.
- R5: When the resolved speed/duplex pair differs from its value one cycle earlier and no recalibration is running, the block pulses `cal_start` and sets bit 15 one cycle later. This covers changes from writes and from the negotiation result.
- R6: A rising edge on `lpbk_pin` sets the loopback bit, and a falling edge clears it. A pin edge takes priority over a write in the same cycle. Software may change the bit between edges.
- R7: `speed_100` and `full_duplex` follow `an_res_100` and `an_res_fdx` while auto-negotiation is enabled. Speed select and duplex writes then have no effect on these outputs. With auto-negotiation off, the outputs follow bits 13 and 8.
- R8: While `compat_mode` is high, writes leave the power-down bit unchanged.
- R9: Writing 1 to bit 9 gives a one-cycle `an_restart` pulse in the cycle after the write. Bit 9 always reads 0.
- R10: While isolate is set, `mii_oe` is 0, every MII-side output and `core_tx*` are 0, and management reads and writes still work. With isolate clear, `mii_oe` is 1 and the signals pass through.
- R11: With loopback set and isolate clear, `mii_rxd`, `mii_rx_dv` and `mii_rx_er` carry `mii_txd`, `mii_tx_en` and `mii_tx_er`. `mii_crs` follows `mii_tx_en`, and `mii_col` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, held at least two cycles |
| strap_an | input | 2 | Auto-negotiation strap; nonzero enables |
| strap_iso_dflt | input | 1 | Isolate default strap |
| strap_phy_addr | input | 5 | PHY address strap |
| lpbk_pin | input | 1 | Loopback pin, edge sensitive |
| compat_mode | input | 1 | Compatibility flag that freezes power down |
| cal_done | input | 1 | Analog recalibration finished |
| cal_start | output | 1 | One-cycle recalibration request |
| an_res_100 | input | 1 | Negotiated speed is 100 Mb/s |
| an_res_fdx | input | 1 | Negotiated full duplex |
| an_restart | output | 1 | One-cycle negotiation restart |
| reg_addr | input | 5 | Management register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data |
| speed_100 | output | 1 | Resolved speed |
| full_duplex | output | 1 | Resolved duplex |
| loopback_en | output | 1 | Loopback control |
| power_down | output | 1 | Power-down control |
| isolate_en | output | 1 | Isolate control |
| col_test | output | 1 | Collision test control |
| phy_tx_clk | input | 1 | Transmit clock from PHY core |
| phy_rx_clk | input | 1 | Receive clock from PHY core |
| phy_rx_dv | input | 1 | Receive data valid from PHY core |
| phy_rx_er | input | 1 | Receive error from PHY core |
| phy_rxd | input | 4 | Receive nibble from PHY core |
| phy_col | input | 1 | Collision from PHY core |
| phy_crs | input | 1 | Carrier sense from PHY core |
| mii_oe | output | 1 | Output enable for MII-side outputs |
| mii_tx_clk | output | 1 | Gated transmit clock |
| mii_rx_clk | output | 1 | Gated receive clock |
| mii_rx_dv | output | 1 | Gated receive data valid |
| mii_rx_er | output | 1 | Gated receive error |
| mii_rxd | output | 4 | Gated receive nibble |
| mii_col | output | 1 | Gated collision |
| mii_crs | output | 1 | Gated carrier sense |
| mii_txd | input | 4 | Transmit nibble from MAC |
| mii_tx_en | input | 1 | Transmit enable from MAC |
| mii_tx_er | input | 1 | Transmit error from MAC |
| core_txd | output | 4 | Transmit nibble to PHY core |
| core_tx_en | output | 1 | Transmit enable to PHY core |
| core_tx_er | output | 1 | Transmit error to PHY core |

## Verification
Every control bit can be read back, so a corrupted bit shows on `reg_rdata` at the very next read, and usually on its control output in the same cycle. A stuck or lost busy flag shows on bit 15 and on `cal_start` one cycle after the edge that should have set or cleared it. Each calibration delay is swept so that the release cycle is checked for every length. Mistakes in gating or loopback are combinational and appear at the MII-side outputs at once, and the bench sweeps every transmit nibble in each isolate and loopback combination.

// File: rtl/phy_ctrl_pkg.sv
`timescale 1ns/1ps
package phy_ctrl_pkg;
    localparam int REG_W = 16;
    // bit positions decoded by the management master
    localparam int B_RST = 15;
    localparam int B_LB  = 14;
    localparam int B_SPD = 13;
    localparam int B_AN  = 12;
    localparam int B_PD  = 11;
    localparam int B_ISO = 10;
    localparam int B_ANR = 9;
    localparam int B_DUP = 8;
    localparam int B_COL = 7;

    typedef struct packed {
        logic an;
        logic spd;
        logic iso;
    } strap_dflt_t;

    typedef struct packed {
        logic       busy;
        logic       lb;
        logic       spd;
        logic       an;
        logic       pd;
        logic       iso;
        logic       dup;
        logic       col;
        logic [1:0] mode;
        logic       cal_start;
        logic       an_rst;
        logic       lb_pin;
    } ctrl_st_t;

    function automatic logic [1:0] resolve_mode(input logic an, input logic spd,
                                                input logic dup, input logic r100,
                                                input logic rfdx);
        return an ? {r100, rfdx} : {spd, dup};
    endfunction
endpackage

// File: rtl/phy_ctrl_strap.sv
`timescale 1ns/1ps
module phy_ctrl_strap
    import phy_ctrl_pkg::*;
#(
    parameter int PA_W = 5,
    parameter int AN_W = 2
) (
    input  logic [AN_W-1:0] strap_an,
    input  logic            strap_iso_dflt,
    input  logic [PA_W-1:0] strap_phy_addr,
    output strap_dflt_t     dflt
);
    always_comb begin
        dflt.an  = |strap_an;
        dflt.spd = |strap_an;
        dflt.iso = (strap_phy_addr == '0) ? 1'b1 : strap_iso_dflt;
    end
endmodule

// File: rtl/phy_ctrl_core.sv
`timescale 1ns/1ps
module phy_ctrl_core
    import phy_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wdata,
    input  strap_dflt_t      dflt,
    input  logic             lpbk_pin,
    input  logic             compat_mode,
    input  logic             cal_done,
    input  logic             an_res_100,
    input  logic             an_res_fdx,
    output ctrl_st_t         st_q,
    output logic             speed_100,
    output logic             full_duplex
);
    localparam logic [REG_W-1:0] WR_MASK = REG_W'(16'hFF80);

    ctrl_st_t         st_d;
    logic [1:0]       mode_now;
    logic [REG_W-1:0] wr_val;

    always_comb begin
        mode_now = resolve_mode(st_q.an, st_q.spd, st_q.dup, an_res_100, an_res_fdx);
        wr_val   = wdata & WR_MASK;
        st_d           = st_q;
        st_d.cal_start = 1'b0;
        st_d.an_rst    = 1'b0;
        st_d.lb_pin    = lpbk_pin;
        st_d.mode      = mode_now;

        if (wr_hit && !st_q.busy) begin
            if (wr_val[B_RST]) begin
                st_d.lb        = 1'b0;
                st_d.spd       = dflt.spd;
                st_d.an        = dflt.an;
                st_d.pd        = 1'b0;
                st_d.iso       = dflt.iso;
                st_d.dup       = 1'b0;
                st_d.col       = 1'b0;
                st_d.busy      = 1'b1;
                st_d.cal_start = 1'b1;
            end else begin
                st_d.lb     = wr_val[B_LB];
                st_d.spd    = wr_val[B_SPD];
                st_d.an     = wr_val[B_AN];
                st_d.iso    = wr_val[B_ISO];
                st_d.dup    = wr_val[B_DUP];
                st_d.col    = wr_val[B_COL];
                st_d.an_rst = wr_val[B_ANR];
                if (!compat_mode) begin
                    st_d.pd = wr_val[B_PD];
                end
            end
        end

        // pin edges win over a write in the same cycle
        if (lpbk_pin && !st_q.lb_pin) begin
            st_d.lb = 1'b1;
        end else if (!lpbk_pin && st_q.lb_pin) begin
            st_d.lb = 1'b0;
        end

        if (st_q.busy) begin
            if (cal_done) begin
                st_d.busy = 1'b0;
            end
        end else if (mode_now != st_q.mode) begin
            st_d.busy      = 1'b1;
            st_d.cal_start = 1'b1;
        end

        if (!rst_n) begin
            st_d        = '0;
            st_d.an     = dflt.an;
            st_d.spd    = dflt.spd;
            st_d.iso    = dflt.iso;
            st_d.lb_pin = lpbk_pin;
            st_d.mode   = mode_now;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign {speed_100, full_duplex} = mode_now;
endmodule

// File: rtl/phy_ctrl_mii.sv
`timescale 1ns/1ps
module phy_ctrl_mii #(
    parameter int NIB_W = 4
) (
    input  logic             iso,
    input  logic             lb,
    input  logic             phy_tx_clk,
    input  logic             phy_rx_clk,
    input  logic             phy_rx_dv,
    input  logic             phy_rx_er,
    input  logic [NIB_W-1:0] phy_rxd,
    input  logic             phy_col,
    input  logic             phy_crs,
    input  logic [NIB_W-1:0] mii_txd,
    input  logic             mii_tx_en,
    input  logic             mii_tx_er,
    output logic             mii_oe,
    output logic             mii_tx_clk,
    output logic             mii_rx_clk,
    output logic             mii_rx_dv,
    output logic             mii_rx_er,
    output logic [NIB_W-1:0] mii_rxd,
    output logic             mii_col,
    output logic             mii_crs,
    output logic [NIB_W-1:0] core_txd,
    output logic             core_tx_en,
    output logic             core_tx_er
);
    always_comb begin
        mii_oe     = !iso;
        mii_tx_clk = 1'b0;
        mii_rx_clk = 1'b0;
        mii_rx_dv  = 1'b0;
        mii_rx_er  = 1'b0;
        mii_rxd    = '0;
        mii_col    = 1'b0;
        mii_crs    = 1'b0;
        core_txd   = '0;
        core_tx_en = 1'b0;
        core_tx_er = 1'b0;
        if (!iso) begin
            mii_tx_clk = phy_tx_clk;
            mii_rx_clk = phy_rx_clk;
            core_txd   = mii_txd;
            core_tx_en = mii_tx_en;
            core_tx_er = mii_tx_er;
            if (lb) begin
                mii_rxd   = mii_txd;
                mii_rx_dv = mii_tx_en;
                mii_rx_er = mii_tx_er;
                mii_crs   = mii_tx_en;
            end else begin
                mii_rxd   = phy_rxd;
                mii_rx_dv = phy_rx_dv;
                mii_rx_er = phy_rx_er;
                mii_col   = phy_col;
                mii_crs   = phy_crs;
            end
        end
    end
endmodule

// File: rtl/phy_basic_ctrl.sv
`timescale 1ns/1ps
module phy_basic_ctrl
    import phy_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int REG_ADDR = 0,
    parameter int PA_W     = 5,
    parameter int AN_W     = 2,
    parameter int NIB_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AN_W-1:0]   strap_an,
    input  logic              strap_iso_dflt,
    input  logic [PA_W-1:0]   strap_phy_addr,
    input  logic              lpbk_pin,
    input  logic              compat_mode,
    input  logic              cal_done,
    output logic              cal_start,
    input  logic              an_res_100,
    input  logic              an_res_fdx,
    output logic              an_restart,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              speed_100,
    output logic              full_duplex,
    output logic              loopback_en,
    output logic              power_down,
    output logic              isolate_en,
    output logic              col_test,
    input  logic              phy_tx_clk,
    input  logic              phy_rx_clk,
    input  logic              phy_rx_dv,
    input  logic              phy_rx_er,
    input  logic [NIB_W-1:0]  phy_rxd,
    input  logic              phy_col,
    input  logic              phy_crs,
    output logic              mii_oe,
    output logic              mii_tx_clk,
    output logic              mii_rx_clk,
    output logic              mii_rx_dv,
    output logic              mii_rx_er,
    output logic [NIB_W-1:0]  mii_rxd,
    output logic              mii_col,
    output logic              mii_crs,
    input  logic [NIB_W-1:0]  mii_txd,
    input  logic              mii_tx_en,
    input  logic              mii_tx_er,
    output logic [NIB_W-1:0]  core_txd,
    output logic              core_tx_en,
    output logic              core_tx_er
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

    strap_dflt_t dflt;
    ctrl_st_t    st_q;
    logic        addr_hit;

    assign addr_hit = (reg_addr == HIT_ADDR);

    phy_ctrl_strap #(.PA_W(PA_W), .AN_W(AN_W)) i_strap (
        .strap_an       (strap_an),
        .strap_iso_dflt (strap_iso_dflt),
        .strap_phy_addr (strap_phy_addr),
        .dflt           (dflt)
    );

    phy_ctrl_core i_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_hit      (reg_wr && addr_hit),
        .wdata       (reg_wdata),
        .dflt        (dflt),
        .lpbk_pin    (lpbk_pin),
        .compat_mode (compat_mode),
        .cal_done    (cal_done),
        .an_res_100  (an_res_100),
        .an_res_fdx  (an_res_fdx),
        .st_q        (st_q),
        .speed_100   (speed_100),
        .full_duplex (full_duplex)
    );

    phy_ctrl_mii #(.NIB_W(NIB_W)) i_mii (
        .iso        (st_q.iso),
        .lb         (st_q.lb),
        .phy_tx_clk (phy_tx_clk),
        .phy_rx_clk (phy_rx_clk),
        .phy_rx_dv  (phy_rx_dv),
        .phy_rx_er  (phy_rx_er),
        .phy_rxd    (phy_rxd),
        .phy_col    (phy_col),
        .phy_crs    (phy_crs),
        .mii_txd    (mii_txd),
        .mii_tx_en  (mii_tx_en),
        .mii_tx_er  (mii_tx_er),
        .mii_oe     (mii_oe),
        .mii_tx_clk (mii_tx_clk),
        .mii_rx_clk (mii_rx_clk),
        .mii_rx_dv  (mii_rx_dv),
        .mii_rx_er  (mii_rx_er),
        .mii_rxd    (mii_rxd),
        .mii_col    (mii_col),
        .mii_crs    (mii_crs),
        .core_txd   (core_txd),
        .core_tx_en (core_tx_en),
        .core_tx_er (core_tx_er)
    );

    always_comb begin
        reg_rdata = '0;
        if (addr_hit) begin
            reg_rdata[B_RST] = st_q.busy;
            reg_rdata[B_LB]  = st_q.lb;
            reg_rdata[B_SPD] = st_q.spd;
            reg_rdata[B_AN]  = st_q.an;
            reg_rdata[B_PD]  = st_q.pd;
            reg_rdata[B_ISO] = st_q.iso;
            reg_rdata[B_DUP] = st_q.dup;
            reg_rdata[B_COL] = st_q.col;
        end
    end

    assign cal_start   = st_q.cal_start;
    assign an_restart  = st_q.an_rst;
    assign loopback_en = st_q.lb;
    assign power_down  = st_q.pd;
    assign isolate_en  = st_q.iso;
    assign col_test    = st_q.col;
endmodule

// File: rtl/phy_basic_ctrl_chk.sv
`timescale 1ns/1ps
module phy_basic_ctrl_chk #(
    parameter int ADDR_W   = 5,
    parameter int REG_ADDR = 0,
    parameter int NIB_W    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              cal_start,
    input logic              cal_done,
    input logic              an_restart,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wr_rst_bit,
    input logic              wr_anr_bit,
    input logic              lpbk_pin,
    input logic              loopback_en,
    input logic              compat_mode,
    input logic              power_down,
    input logic              isolate_en,
    input logic              col_test,
    input logic              an_en,
    input logic              speed_100,
    input logic              an_res_100,
    input logic              mii_oe,
    input logic [NIB_W-1:0]  mii_rxd
);
    logic wr_hit;
    assign wr_hit = reg_wr && (reg_addr == ADDR_W'(REG_ADDR));

    // R3
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cal_done |=> !busy);

    // R3
    cal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start);

    // R4
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({power_down, isolate_en, col_test, an_en}));

    // R6
    lpbk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lpbk_pin) |=> loopback_en);

    // R6
    lpbk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lpbk_pin) |=> !loopback_en);

    // R7
    an_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        an_en |-> speed_100 == an_res_100);

    // R8
    compat_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        compat_mode && !(wr_hit && wr_rst_bit) |=> $stable(power_down));

    // R9
    restart_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart |-> $past(wr_hit) && $past(wr_anr_bit));

    // R10
    isolate_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isolate_en |-> !mii_oe && mii_rxd == '0);
endmodule

bind phy_basic_ctrl phy_basic_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .NIB_W    (NIB_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (st_q.busy),
    .cal_start   (cal_start),
    .cal_done    (cal_done),
    .an_restart  (an_restart),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .wr_rst_bit  (reg_wdata[15]),
    .wr_anr_bit  (reg_wdata[9]),
    .lpbk_pin    (lpbk_pin),
    .loopback_en (loopback_en),
    .compat_mode (compat_mode),
    .power_down  (power_down),
    .isolate_en  (isolate_en),
    .col_test    (col_test),
    .an_en       (st_q.an),
    .speed_100   (speed_100),
    .an_res_100  (an_res_100),
    .mii_oe      (mii_oe),
    .mii_rxd     (mii_rxd)
);

// File: tb/test_phy_basic_ctrl.sv
`timescale 1ns/1ps
module test_phy_basic_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] strap_an = 2'd0;
    logic strap_iso_dflt = 1'b0;
    logic [4:0] strap_phy_addr = 5'd1;
    logic lpbk_pin = 1'b0, compat_mode = 1'b0, cal_done = 1'b0, cal_start;
    logic an_res_100 = 1'b0, an_res_fdx = 1'b0, an_restart;
    logic [4:0] reg_addr = 5'd0;
    logic reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'd0, reg_rdata;
    logic speed_100, full_duplex, loopback_en, power_down, isolate_en, col_test;
    logic phy_tx_clk = 1'b0, phy_rx_clk = 1'b0, phy_rx_dv = 1'b0, phy_rx_er = 1'b0;
    logic [3:0] phy_rxd = 4'd0;
    logic phy_col = 1'b0, phy_crs = 1'b0;
    logic mii_oe, mii_tx_clk, mii_rx_clk, mii_rx_dv, mii_rx_er, mii_col, mii_crs;
    logic [3:0] mii_rxd, core_txd;
    logic [3:0] mii_txd = 4'd0;
    logic mii_tx_en = 1'b0, mii_tx_er = 1'b0, core_tx_en, core_tx_er;

    int n_chk = 0, n_fail = 0;
    bit m_lb, m_spd, m_an, m_pd, m_iso, m_dup, m_col;

    always #4 clk = ~clk;

    phy_basic_ctrl i_phy_basic_ctrl (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    function automatic logic [15:0] exp_rd(input bit busy);
        return {busy, m_lb, m_spd, m_an, m_pd, m_iso, 1'b0, m_dup, m_col, 7'd0};
    endfunction

    function automatic logic [1:0] mres();
        return m_an ? {an_res_100, an_res_fdx} : {m_spd, m_dup};
    endfunction

    function automatic logic [15:0] mkw(input bit lb, input bit spd, input bit an,
                                        input bit pd, input bit iso, input bit anr,
                                        input bit dup, input bit col);
        return {1'b0, lb, spd, an, pd, iso, anr, dup, col, 7'h2B};
    endfunction

    task automatic load_dflt;
        m_lb = 0; m_pd = 0; m_dup = 0; m_col = 0;
        m_an = (strap_an != 0); m_spd = (strap_an != 0);
        m_iso = (strap_phy_addr == 0) ? 1'b1 : strap_iso_dflt;
    endtask

    task automatic wr(input logic [15:0] v);
        reg_wr = 1'b1;
        reg_wdata = v;
        tick();
        reg_wr = 1'b0;
    endtask

    // bit 15 reads 1 for dly more cycles, then cal_done ends it
    task automatic run_cal(input int dly);
        for (int i = 0; i < dly; i++) begin
            chk("R3", "busy held", 32'(reg_rdata[15]), 1);
            tick();
        end
        cal_done = 1'b1;
        chk("R3", "busy before done", 32'(reg_rdata[15]), 1);
        tick();
        cal_done = 1'b0;
        chk("R3", "busy released", 32'(reg_rdata[15]), 0);
    endtask

    task automatic wr_chk(input logic [15:0] v, input int dly, input string req);
        logic [1:0] old_mode;
        old_mode = mres();
        wr(v);
        m_lb = v[14]; m_spd = v[13]; m_an = v[12]; m_iso = v[10];
        m_dup = v[8]; m_col = v[7];
        if (!compat_mode) m_pd = v[11];
        chk(req, "readback", 32'(reg_rdata), 32'(exp_rd(0)));
        chk(req, "controls", 32'({loopback_en, power_down, isolate_en, col_test}),
            32'({m_lb, m_pd, m_iso, m_col}));
        chk("R7", "resolved mode", 32'({speed_100, full_duplex}), 32'(mres()));
        chk("R9", "restart pulse", 32'(an_restart), 32'(v[9]));
        tick();
        chk("R9", "restart cleared", 32'(an_restart), 0);
        if (mres() != old_mode) begin
            chk("R5", "cal_start on mode change", 32'(cal_start), 1);
            chk("R5", "busy on mode change", 32'(reg_rdata[15]), 1);
            run_cal(dly);
        end else begin
            chk("R5", "no cal_start", 32'(cal_start), 0);
        end
    endtask

    task automatic do_reset(input logic [1:0] an, input bit isod, input logic [4:0] pa);
        rst_n = 1'b0;
        strap_an = an; strap_iso_dflt = isod; strap_phy_addr = pa;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        load_dflt();
    endtask

    function automatic logic [16:0] mii_exp(input bit iso, input bit lb);
        if (iso) return 17'd0;
        return {1'b1, phy_tx_clk, phy_rx_clk,
                lb ? mii_tx_en : phy_rx_dv, lb ? mii_tx_er : phy_rx_er,
                lb ? mii_txd : phy_rxd, lb ? 1'b0 : phy_col,
                lb ? mii_tx_en : phy_crs, mii_txd, mii_tx_en, mii_tx_er};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        // R1: every strap combination
        for (int a = 0; a < 4; a++)
            for (int s = 0; s < 2; s++)
                for (int p = 0; p < 32; p++) begin
                    do_reset(2'(a), 1'(s), 5'(p));
                    chk("R1", "strap default", 32'(reg_rdata), 32'(exp_rd(0)));
                end
        do_reset(2'd0, 1'b0, 5'd1);
        chk("R1", "idle pulses", 32'({cal_start, an_restart}), 0);
        chk("R10", "oe after reset", 32'(mii_oe), 1);

        // R2: other address reads zero
        reg_addr = 5'd3;
        #1 chk("R2", "other address", 32'(reg_rdata), 0);
        reg_addr = 5'd0;

        // R2, R5, R7: sweep writable bits with negotiation off
        for (int i = 0; i < 64; i++)
            wr_chk({1'b0, i[0], i[1], 1'b0, i[2], i[3], 1'b0, i[4], i[5], 7'h5A}, i % 4, "R2");

        // R9
        wr_chk(mkw(0, 0, 0, 0, 0, 1, 0, 0), 1, "R9");

        // R7, R5: negotiation on, result changes trigger recalibration
        wr_chk(mkw(0, 1, 1, 0, 0, 0, 1, 0), 2, "R7");
        for (int c = 1; c < 4; c++) begin
            {an_res_100, an_res_fdx} = 2'(c);
            tick();
            chk("R5", "cal on result change", 32'(cal_start), 1);
            run_cal(c);
            chk("R7", "negotiated mode", 32'({speed_100, full_duplex}), 32'(c));
        end
        wr_chk(mkw(0, 0, 1, 0, 0, 0, 0, 0), 1, "R7");
        wr_chk(mkw(0, 1, 0, 0, 0, 0, 1, 0), 1, "R7");
        {an_res_100, an_res_fdx} = 2'd0;

        // R8
        compat_mode = 1'b1;
        wr_chk(mkw(0, 1, 0, 1, 0, 0, 1, 1), 1, "R8");
        chk("R8", "pd frozen low", 32'(power_down), 0);
        compat_mode = 1'b0;
        wr_chk(mkw(0, 1, 0, 1, 0, 0, 1, 1), 1, "R8");
        compat_mode = 1'b1;
        wr_chk(mkw(0, 1, 0, 0, 0, 0, 1, 1), 1, "R8");
        chk("R8", "pd frozen high", 32'(power_down), 1);
        compat_mode = 1'b0;

        // R6
        lpbk_pin = 1'b1; tick(); m_lb = 1;
        chk("R6", "pin rise", 32'(reg_rdata), 32'(exp_rd(0)));
        wr_chk(mkw(0, m_spd, 0, m_pd, 0, 0, m_dup, m_col), 1, "R6");
        lpbk_pin = 1'b0; tick();
        chk("R6", "fall keeps clear", 32'(loopback_en), 0);
        lpbk_pin = 1'b1; tick();
        chk("R6", "second rise", 32'(loopback_en), 1);
        reg_wr = 1'b1; reg_wdata = mkw(0, m_spd, 0, m_pd, 0, 0, m_dup, m_col);
        lpbk_pin = 1'b0;
        tick(); reg_wr = 1'b0;
        chk("R6", "fall beats write", 32'(loopback_en), 0);
        wr_chk(mkw(1, m_spd, 0, m_pd, 0, 0, m_dup, m_col), 1, "R6");
        lpbk_pin = 1'b1; tick(); tick(); lpbk_pin = 1'b0; tick(); m_lb = 0;
        chk("R6", "pin clears written bit", 32'(reg_rdata), 32'(exp_rd(0)));

        // R3, R4: soft reset with several calibration lengths
        for (int d = 0; d < 4; d++) begin
            strap_an = 2'(d); strap_phy_addr = 5'(d); strap_iso_dflt = 1'(d);
            wr_chk(mkw(0, 1, 0, 1, 1, 0, 1, 1), 1, "R3");
            wr(16'hFFFF);
            load_dflt();
            chk("R3", "cal_start", 32'(cal_start), 1);
            chk("R3", "defaults busy", 32'(reg_rdata), 32'(exp_rd(1)));
            wr(16'h7D80);
            chk("R4", "write ignored", 32'(reg_rdata), 32'(exp_rd(1)));
            chk("R4", "no second cal", 32'(cal_start), 0);
            run_cal(d);
            chk("R3", "defaults idle", 32'(reg_rdata), 32'(exp_rd(0)));
        end
        strap_an = 2'd0;
        wr_chk(mkw(0, 0, 0, 0, 0, 0, 0, 0), 1, "R2");

        // R10, R11
        for (int k = 0; k < 4; k++) begin
            wr_chk(mkw(k[0], 0, 0, 0, k[1], 0, 0, 0), 1, k[1] ? "R10" : "R11");
            for (int t = 0; t < 16; t++) begin
                mii_txd = 4'(t); mii_tx_en = t[0]; mii_tx_er = t[1];
                phy_rxd = ~4'(t); phy_rx_dv = t[2]; phy_rx_er = t[3];
                phy_col = t[0]; phy_crs = ~t[1];
                phy_tx_clk = t[2]; phy_rx_clk = t[3];
                #1;
                chk(k[1] ? "R10" : "R11", "mii path",
                    32'({mii_oe, mii_tx_clk, mii_rx_clk, mii_rx_dv, mii_rx_er, mii_rxd,
                         mii_col, mii_crs, core_txd, core_tx_en, core_tx_er}),
                    32'(mii_exp(k[1], k[0])));
            end
        end
        report();
    end
endmodule